// File: doc/BRIEF.md
# Debug Emulation Mode Controller

This block follows whether a processor core is running in a debug emulation mode. The core, its caches and the breakpoint comparators sit outside the block. They appear here only as single-cycle strobes and attribute buses. There are three ways into the mode:

- a forcing control bit, sampled only at the moment reset exception processing begins;
- a debug interrupt;
- a trace exception, but only while a trace-forcing control bit is set.

A return-from-exception that retires while the core is in the mode takes it out again.

The block sits beside the core's status and bus attribute paths. On the entry cycle it replaces the core's processor-status code with 0xD, and on the exit cycle with 0x7. From the exit cycle until the next instruction completes, it blocks hardware breakpoint triggers and new debug interrupts. It flags interrupt stack frames built while in the mode. When mapping is enabled, it moves every access into a dedicated attribute space and inhibits caching and local SRAM.

Top module: `emu_mode_ctrl`

## Requirements
- R1: After reset, emu_o is 0, no post-exit inhibit is pending (bkpt_trig_o follows bkpt_trig_i), and pst_o follows core_pst_i.
- R2: force_emu_i causes entry only in a cycle where reset_exc_start_i is 1; at any other time force_emu_i has no effect on emu_o or pst_o.
- R3: debug_irq_i causes entry unless the post-exit inhibit is pending, in which case it is ignored.
- R4: trace_exc_i causes entry only when trace_force_i is 1 in the same cycle.
- R5: In the cycle an entry event occurs while emu_o is 0, pst_o is 4'hD and emu_o is 1 from the next cycle; while emu_o is already 1, entry events change nothing and pst_o is not forced to 4'hD.
- R6: rte_retire_i while emu_o is 1 drives pst_o to 4'h7 in that cycle and clears emu_o in the next; rte_retire_i while emu_o is 0 has no effect.
- R7: In every cycle that is neither an entry nor an exit cycle, pst_o equals core_pst_i.
- R8: bkpt_trig_o is 0 from the exit cycle up to and including the cycle in which the first insn_retire_i after the exit cycle is seen; otherwise it equals bkpt_trig_i.
- R9: frame_fs1_o is 1 exactly when irq_exc_i is 1 and emu_o is 1.
- R10: When map_en_i is 1 and the block is in the mode or in an entry cycle, bus_tt_o is 2, bus_tm_o is 6 for instruction accesses (acc_insn_i = 1) and 5 for data accesses, and cache_inh_o and sram_inh_o are 1.
- R11: Otherwise bus_tt_o and bus_tm_o pass bus_tt_i and bus_tm_i unchanged, and cache_inh_o and sram_inh_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_emu_i | input | 1 | Forcing control bit |
| reset_exc_start_i | input | 1 | Reset exception processing begins |
| trace_force_i | input | 1 | Trace-forcing control bit |
| trace_exc_i | input | 1 | Trace exception processing begins |
| debug_irq_i | input | 1 | Debug interrupt exception begins |
| rte_retire_i | input | 1 | Return-from-exception retires |
| insn_retire_i | input | 1 | Any instruction completes |
| irq_exc_i | input | 1 | Unmasked interrupt exception begins |
| bkpt_trig_i | input | 1 | Raw breakpoint trigger from comparators |
| map_en_i | input | 1 | Map control bit |
| core_pst_i | input | PST_W | Core processor-status code |
| bus_tt_i | input | TT_W | Core transfer type |
| bus_tm_i | input | TM_W | Core transfer modifier |
| acc_insn_i | input | 1 | Current access is an instruction fetch |
| emu_o | output | 1 | Core is in emulation mode |
| pst_o | output | PST_W | Processor-status code to the pins |
| bkpt_trig_o | output | 1 | Qualified breakpoint trigger |
| frame_fs1_o | output | 1 | Set format bit FS[1] in the stack frame |
| bus_tt_o | output | TT_W | Transfer type to the bus |
| bus_tm_o | output | TM_W | Transfer modifier to the bus |
| cache_inh_o | output | 1 | Inhibit caching |
| sram_inh_o | output | 1 | Inhibit local SRAM |

## Verification
The bench uses the default widths: a 4-bit status code, a 2-bit transfer type and a 3-bit transfer modifier. At these widths every status and attribute value the core can present is small enough to be visited many times. Several thousand cycles of mixed stimulus sweep all combinations of the entry strobes, both mode states and the inhibit window. They include entry strobes arriving while already in the mode, RTE arriving outside the mode, and debug interrupts landing inside the inhibit window. Each remapped access is checked against both the instruction and the data modifier.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int unsigned PST_W_DEF = 4;
  localparam int unsigned TT_W_DEF  = 2;
  localparam int unsigned TM_W_DEF  = 3;

  typedef struct packed {
    logic reset_force;
    logic dbg;
    logic trace;
  } entry_src_t;
endpackage

// File: rtl/emu_entry_det.sv
module emu_entry_det
  import emu_pkg::*;
(
  input  logic       emu_q_i,
  input  logic       inhibit_q_i,
  input  logic       force_emu_i,
  input  logic       reset_exc_start_i,
  input  logic       trace_force_i,
  input  logic       trace_exc_i,
  input  logic       debug_irq_i,
  output entry_src_t src_o,
  output logic       enter_o
);
  always_comb begin
    src_o.reset_force = force_emu_i & reset_exc_start_i;
    src_o.dbg         = debug_irq_i & ~inhibit_q_i;
    src_o.trace       = trace_exc_i & trace_force_i;
  end

  // already in mode: no fresh entry, no second entry code
  assign enter_o = (|src_o) & ~emu_q_i;
endmodule

// File: rtl/emu_state.sv
module emu_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic rte_retire_i,
  input  logic insn_retire_i,
  output logic emu_q_o,
  output logic inhibit_q_o,
  output logic exit_o
);
  logic emu_q, inhibit_q;

  assign exit_o = rte_retire_i & emu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emu_q     <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      if (enter_i)     emu_q <= 1'b1;
      else if (exit_o) emu_q <= 1'b0;
      // set wins: the RTE's own retire does not end the window
      if (exit_o)                      inhibit_q <= 1'b1;
      else if (insn_retire_i)          inhibit_q <= 1'b0;
    end
  end

  assign emu_q_o     = emu_q;
  assign inhibit_q_o = inhibit_q;
endmodule

// File: rtl/emu_pst_mux.sv
module emu_pst_mux #(
  parameter int unsigned       PST_W     = 4,
  parameter logic [PST_W-1:0]  PST_ENTER = 4'hD,
  parameter logic [PST_W-1:0]  PST_EXIT  = 4'h7
) (
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic [PST_W-1:0] core_pst_i,
  output logic [PST_W-1:0] pst_o
);
  always_comb begin
    if (enter_i)     pst_o = PST_ENTER;
    else if (exit_i) pst_o = PST_EXIT;
    else             pst_o = core_pst_i;
  end
endmodule

// File: rtl/emu_attr_remap.sv
module emu_attr_remap #(
  parameter int unsigned      TT_W    = 2,
  parameter int unsigned      TM_W    = 3,
  parameter logic [TT_W-1:0]  TT_EMU  = 2,
  parameter logic [TM_W-1:0]  TM_DATA = 5,
  parameter logic [TM_W-1:0]  TM_INSN = 6
) (
  input  logic            active_i,
  input  logic            map_en_i,
  input  logic            acc_insn_i,
  input  logic [TT_W-1:0] bus_tt_i,
  input  logic [TM_W-1:0] bus_tm_i,
  output logic [TT_W-1:0] bus_tt_o,
  output logic [TM_W-1:0] bus_tm_o,
  output logic            cache_inh_o,
  output logic            sram_inh_o
);
  logic remap;
  assign remap = active_i & map_en_i;

  always_comb begin
    bus_tt_o    = bus_tt_i;
    bus_tm_o    = bus_tm_i;
    cache_inh_o = 1'b0;
    sram_inh_o  = 1'b0;
    if (remap) begin
      bus_tt_o    = TT_EMU;
      bus_tm_o    = acc_insn_i ? TM_INSN : TM_DATA;
      cache_inh_o = 1'b1;
      sram_inh_o  = 1'b1;
    end
  end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
  import emu_pkg::*;
#(
  parameter int unsigned PST_W = PST_W_DEF,
  parameter int unsigned TT_W  = TT_W_DEF,
  parameter int unsigned TM_W  = TM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_emu_i,
  input  logic             reset_exc_start_i,
  input  logic             trace_force_i,
  input  logic             trace_exc_i,
  input  logic             debug_irq_i,
  input  logic             rte_retire_i,
  input  logic             insn_retire_i,
  input  logic             irq_exc_i,
  input  logic             bkpt_trig_i,
  input  logic             map_en_i,
  input  logic [PST_W-1:0] core_pst_i,
  input  logic [TT_W-1:0]  bus_tt_i,
  input  logic [TM_W-1:0]  bus_tm_i,
  input  logic             acc_insn_i,
  output logic             emu_o,
  output logic [PST_W-1:0] pst_o,
  output logic             bkpt_trig_o,
  output logic             frame_fs1_o,
  output logic [TT_W-1:0]  bus_tt_o,
  output logic [TM_W-1:0]  bus_tm_o,
  output logic             cache_inh_o,
  output logic             sram_inh_o
);
  localparam logic [PST_W-1:0] PST_ENTER = PST_W'(4'hD);
  localparam logic [PST_W-1:0] PST_EXIT  = PST_W'(4'h7);
  localparam logic [TT_W-1:0]  TT_EMU    = TT_W'(2);
  localparam logic [TM_W-1:0]  TM_DATA   = TM_W'(5);
  localparam logic [TM_W-1:0]  TM_INSN   = TM_W'(6);

  entry_src_t src;
  logic enter, exit_evt, emu_q, inhibit_q;

  emu_entry_det u_entry (
    .emu_q_i           (emu_q),
    .inhibit_q_i       (inhibit_q),
    .force_emu_i       (force_emu_i),
    .reset_exc_start_i (reset_exc_start_i),
    .trace_force_i     (trace_force_i),
    .trace_exc_i       (trace_exc_i),
    .debug_irq_i       (debug_irq_i),
    .src_o             (src),
    .enter_o           (enter)
  );

  emu_state u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (enter),
    .rte_retire_i  (rte_retire_i),
    .insn_retire_i (insn_retire_i),
    .emu_q_o       (emu_q),
    .inhibit_q_o   (inhibit_q),
    .exit_o        (exit_evt)
  );

  emu_pst_mux #(
    .PST_W     (PST_W),
    .PST_ENTER (PST_ENTER),
    .PST_EXIT  (PST_EXIT)
  ) u_pst (
    .enter_i    (enter),
    .exit_i     (exit_evt),
    .core_pst_i (core_pst_i),
    .pst_o      (pst_o)
  );

  // entering exception's own frame writes and vector fetch are remapped
  emu_attr_remap #(
    .TT_W    (TT_W),
    .TM_W    (TM_W),
    .TT_EMU  (TT_EMU),
    .TM_DATA (TM_DATA),
    .TM_INSN (TM_INSN)
  ) u_remap (
    .active_i    (emu_q | enter),
    .map_en_i    (map_en_i),
    .acc_insn_i  (acc_insn_i),
    .bus_tt_i    (bus_tt_i),
    .bus_tm_i    (bus_tm_i),
    .bus_tt_o    (bus_tt_o),
    .bus_tm_o    (bus_tm_o),
    .cache_inh_o (cache_inh_o),
    .sram_inh_o  (sram_inh_o)
  );

  assign emu_o       = emu_q;
  assign bkpt_trig_o = bkpt_trig_i & ~inhibit_q & ~exit_evt;
  assign frame_fs1_o = irq_exc_i & emu_q;

  logic unused_src;
  assign unused_src = ^src;
endmodule

// File: rtl/emu_mode_chk.sv
module emu_mode_chk #(
  parameter int unsigned PST_W = 4,
  parameter int unsigned TT_W  = 2,
  parameter int unsigned TM_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enter,
  input logic             exit_evt,
  input logic             inhibit_q,
  input logic             emu_o,
  input logic             rte_retire_i,
  input logic             map_en_i,
  input logic             irq_exc_i,
  input logic [PST_W-1:0] core_pst_i,
  input logic [PST_W-1:0] pst_o,
  input logic             bkpt_trig_o,
  input logic             frame_fs1_o,
  input logic [TT_W-1:0]  bus_tt_o,
  input logic             cache_inh_o
);
  a_r5_entry_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |-> pst_o == PST_W'(4'hD));
  a_r5_entry_sets_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> emu_o);
  a_r5_no_reemit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_o && core_pst_i != PST_W'(4'hD)) |-> pst_o != PST_W'(4'hD));
  a_r6_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_o && rte_retire_i) |=> !emu_o);
  a_r6_exit_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_evt |-> pst_o == PST_W'(4'h7));
  a_r8_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_q || exit_evt) |-> !bkpt_trig_o);
  a_r8_inhibit_follows_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_evt |=> inhibit_q);
  a_r9_fs1_only_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fs1_o |-> (emu_o && irq_exc_i));
  a_r10_remap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_o && map_en_i) |-> (bus_tt_o == TT_W'(2) && cache_inh_o));
  a_r11_no_remap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_i |-> !cache_inh_o);
endmodule

bind emu_mode_ctrl emu_mode_chk #(
  .PST_W (PST_W),
  .TT_W  (TT_W),
  .TM_W  (TM_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enter        (enter),
  .exit_evt     (exit_evt),
  .inhibit_q    (inhibit_q),
  .emu_o        (emu_o),
  .rte_retire_i (rte_retire_i),
  .map_en_i     (map_en_i),
  .irq_exc_i    (irq_exc_i),
  .core_pst_i   (core_pst_i),
  .pst_o        (pst_o),
  .bkpt_trig_o  (bkpt_trig_o),
  .frame_fs1_o  (frame_fs1_o),
  .bus_tt_o     (bus_tt_o),
  .cache_inh_o  (cache_inh_o)
);

// File: tb/emu_mode_ctrl_tb.sv
module emu_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic fe, rs, tf, te, dbg, rte, ret, irq, bk, map, insn;
  logic [3:0] cpst;
  logic [1:0] tt;
  logic [2:0] tm;
  logic emu, bko, fs1, cinh, sinh;
  logic [3:0] pst;
  logic [1:0] tto;
  logic [2:0] tmo;

  emu_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .force_emu_i(fe), .reset_exc_start_i(rs), .trace_force_i(tf),
    .trace_exc_i(te), .debug_irq_i(dbg), .rte_retire_i(rte),
    .insn_retire_i(ret), .irq_exc_i(irq), .bkpt_trig_i(bk),
    .map_en_i(map), .core_pst_i(cpst), .bus_tt_i(tt), .bus_tm_i(tm),
    .acc_insn_i(insn), .emu_o(emu), .pst_o(pst), .bkpt_trig_o(bko),
    .frame_fs1_o(fs1), .bus_tt_o(tto), .bus_tm_o(tmo),
    .cache_inh_o(cinh), .sram_inh_o(sinh)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic m_emu = 1'b0;
  logic m_inh = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    {fe, rs, tf, te, dbg, rte, ret, irq, bk, map, insn} = '0;
    cpst = 4'h0; tt = 2'd0; tm = 3'd0;
  endtask

  // drive at negedge, check before the next posedge, then advance the model
  task automatic step();
    logic src, ent, ex, remap;
    #2;
    src   = (fe & rs) | (dbg & ~m_inh) | (te & tf);
    ent   = src & ~m_emu;
    ex    = rte & m_emu;
    remap = (m_emu | ent) & map;
    chk("R5 emu state", int'(emu), int'(m_emu));
    if (ent)     chk("R5 entry code", int'(pst), 'hD);
    else if (ex) chk("R6 exit code", int'(pst), 'h7);
    else         chk("R7 pst passthrough", int'(pst), int'(cpst));
    chk("R8 breakpoint gate", int'(bko), int'(bk & ~m_inh & ~ex));
    chk("R9 frame FS1", int'(fs1), int'(irq & m_emu));
    if (remap) begin
      chk("R10 tt remap", int'(tto), 2);
      chk("R10 tm remap", int'(tmo), insn ? 6 : 5);
      chk("R10 cache/sram inhibit", int'({cinh, sinh}), 3);
    end else begin
      chk("R11 tt pass", int'(tto), int'(tt));
      chk("R11 tm pass", int'(tmo), int'(tm));
      chk("R11 no inhibit", int'({cinh, sinh}), 0);
    end
    @(posedge clk);
    m_emu = ent | (m_emu & ~ex);
    m_inh = ex | (m_inh & ~ret);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cpst = 4'h3; bk = 1'b1;
    #2;
    chk("R1 emu after reset", int'(emu), 0);
    chk("R1 pst after reset", int'(pst), 3);
    chk("R1 bkpt after reset", int'(bko), 1);
    @(negedge clk);
    // R2: force bit without reset-exception start is ignored
    drive_idle(); fe = 1'b1; cpst = 4'h5;
    step();
    chk("R2 force ignored", int'(emu), 0);
    // R2: force at reset-exception start enters
    rs = 1'b1; step();
    drive_idle(); cpst = 4'hD; step();   // R5 core code D passes in mode
    chk("R2 forced entry", int'(emu), 1);
    rte = 1'b1; ret = 1'b1; step();      // R6 exit
    drive_idle(); dbg = 1'b1; bk = 1'b1; step(); // R3 dbg blocked, R8 gated
    chk("R3 dbg during inhibit", int'(emu), 0);
    ret = 1'b1; step();
    drive_idle(); rte = 1'b1; step();    // R6 rte outside mode ignored
    te = 1'b1; step();                   // R4 no trace force
    chk("R4 trace without force", int'(emu), 0);
    tf = 1'b1; map = 1'b1; step();       // R4 entry, R10 on entry cycle
    drive_idle(); map = 1'b1; insn = 1'b1; step();
    insn = 1'b0; irq = 1'b1; step();
    drive_idle(); rte = 1'b1; step();
    drive_idle(); ret = 1'b1; step();

    // near-exhaustive mixed sweep
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      {fe, rs, tf, te} = r[3:0];
      dbg  = (r[6:4] == 3'd0);
      rte  = (r[8:7] == 2'd0);
      ret  = r[9] | r[10];
      irq  = r[11];
      bk   = r[12];
      map  = r[13];
      insn = r[14];
      cpst = r[18:15];
      tt   = r[20:19];
      tm   = r[23:21];
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule